// File: doc/BRIEF.md
# Asynchronous FIFO Read Sequencer

This block sits on the master side of a link to an asynchronous slave FIFO. It drives the chip select, output enable, read strobe and FIFO address pins in the order that such a FIFO expects. It then pulls either one word or a burst of words out of the selected FIFO. A requester hands over a FIFO address and a word count on a one-cycle request. Each word is returned on a response port with a one-cycle valid pulse. A done pulse then reports how many words were actually read. Every timing window is a parameter counted in clock cycles.

Output enable is opened before the first strobe. Whatever word sits on the bus at that point is left out of the responses. During a burst, chip select and output enable stay asserted while the strobe toggles once per word. Each low phase and each high phase is held for at least its configured width. Data is captured a fixed number of cycles after each falling strobe edge. Before every beat the sequencer looks at a synchronized copy of the FIFO's empty flag, and ends the burst early when no data remains.

The controller has nine states. `S_IDLE` leaves on a request: to `S_SETUP` for a non-zero count, or straight to `S_FINISH` for a zero count. `S_SETUP` (address and chip select only) moves to `S_OPEN` after the setup time. `S_OPEN` (output enable on) moves to `S_CHECK` after the lead time. `S_CHECK` goes to `S_STRB_LO` while words remain and the flag shows data, and to `S_CLOSE_OE` otherwise. `S_STRB_LO` moves to `S_STRB_HI` after the low width, and `S_STRB_HI` moves back to `S_CHECK` after the high width. `S_CLOSE_OE` (output enable off) moves to `S_RELEASE` after the turn-off time. `S_RELEASE` (chip select off, address held) moves to `S_FINISH` after the hold time. `S_FINISH` raises done and returns to `S_IDLE`.

Top module: `fifo_rd_seq`

## Requirements
- R1: Chip select is asserted (low) before output enable. Output enable is asserted (low) in the cycle before every falling edge of the read strobe. The strobe is never low while output enable or chip select is high.
- R2: No response is produced for the word on the bus while output enable is low and the strobe has not yet fallen. rsp_valid is high only in the cycle after a cycle in which the strobe was low.
- R3: Every low phase of the read strobe lasts at least T_LOW cycles.
- R4: Between two beats of one request, every high phase of the strobe lasts at least T_HIGH cycles.
- R5: The word of each beat is captured exactly T_DV cycles after the strobe falls. The captured words are returned in FIFO order, with T_DV no greater than T_LOW.
- R6: During one request, output enable falls once and rises once, and chip select likewise, however many beats the burst has.
- R7: fifo_addr equals the accepted req_addr and does not change while chip select is asserted. It stays unchanged for at least T_OEOFF + T_HOLD cycles after the last strobe rises.
- R8: fifo_empty (active high, asynchronous) is synchronized and checked before each beat. The burst stops after min(req_count, words available) beats, and done_count reports that number.
- R9: At the end of a request, output enable goes high first and then chip select, and only then does done pulse for one cycle. busy stays high from acceptance through the done cycle, and a request presented while busy is ignored.
- R10: A request with req_count = 0 raises done in the next cycle with done_count = 0, and there is no chip select, output enable or strobe activity.
- R11: During reset, fifo_cs_n, fifo_oe_n and fifo_rd_n are high, and busy, done and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only when busy is low |
| req_addr | input | AW | FIFO address to read from |
| req_count | input | CW | Number of words wanted |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle pulse marking a captured word |
| rsp_data | output | DW | Captured word |
| done | output | 1 | One-cycle pulse at the end of a request |
| done_count | output | CW | Words actually read, valid with done |
| fifo_cs_n | output | 1 | Chip select to the FIFO, active low |
| fifo_oe_n | output | 1 | Output enable to the FIFO, active low |
| fifo_rd_n | output | 1 | Read strobe to the FIFO, active low |
| fifo_addr | output | AW | FIFO address pins |
| fifo_data | input | DW | FIFO data bus |
| fifo_empty | input | 1 | FIFO empty flag, active high, asynchronous |

## Verification
The bench builds the block with T_LOW = T_DV = 3, which puts the capture on the last cycle of the low phase. It sets T_HIGH = 2, the smallest high width that still lets the two-stage flag synchronizer see a strobe's effect before the next beat. It also uses T_OELEAD = 1, T_SETUP = 2, T_OEOFF = 1 and T_HOLD = 2, with CW = 6 so that a full-length burst of 63 words fits in the run. The FIFO model puts garbage on the bus until T_DV cycles after each falling strobe edge, so a capture one cycle too early is seen. It also shows a non-data stale word while output enable is open and the strobe is high. Bursts that end on the count and bursts that end on the empty flag are both reached.

// File: rtl/fifo_rd_seq_pkg.sv
package fifo_rd_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_OPEN,
        S_CHECK,
        S_STRB_LO,
        S_STRB_HI,
        S_CLOSE_OE,
        S_RELEASE,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/fifo_rd_flag_sync.sv
module fifo_rd_flag_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/fifo_rd_phase_timer.sv
module fifo_rd_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] elapsed
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 elapsed <= '0;
        else if (restart)           elapsed <= '0;
        else if (elapsed != '1)     elapsed <= elapsed + 1'b1;
    end

endmodule

// File: rtl/fifo_rd_seq.sv
module fifo_rd_seq
    import fifo_rd_seq_pkg::*;
#(
    parameter int AW        = 2,
    parameter int DW        = 16,
    parameter int CW        = 8,
    parameter int T_SETUP   = 2,
    parameter int T_OELEAD  = 1,
    parameter int T_LOW     = 4,
    parameter int T_HIGH    = 3,
    parameter int T_DV      = 3,
    parameter int T_HOLD    = 2,
    parameter int T_OEOFF   = 1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_count,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          done,
    output logic [CW-1:0] done_count,
    output logic          fifo_cs_n,
    output logic          fifo_oe_n,
    output logic          fifo_rd_n,
    output logic [AW-1:0] fifo_addr,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_empty
);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_MAX = max2(max2(max2(T_SETUP, T_OELEAD), max2(T_LOW, T_HIGH)),
                                max2(max2(T_DV, T_HOLD), T_OEOFF));
    localparam int TW = $clog2(T_MAX + 1) + 1;

    localparam logic [TW-1:0] SETUP_LAST = TW'(T_SETUP - 1);
    localparam logic [TW-1:0] LEAD_LAST  = TW'(T_OELEAD - 1);
    localparam logic [TW-1:0] LOW_LAST   = TW'(T_LOW - 1);
    localparam logic [TW-1:0] HIGH_LAST  = TW'(T_HIGH - 1);
    localparam logic [TW-1:0] DV_LAST    = TW'(T_DV - 1);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(T_HOLD - 1);
    localparam logic [TW-1:0] OFF_LAST   = TW'(T_OEOFF - 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] elapsed;
    logic          empty_s;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] words_q;
    logic          more_words;
    logic          capture;

    fifo_rd_flag_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_empty_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fifo_empty),
        .sync_out (empty_s)
    );

    fifo_rd_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .elapsed (elapsed)
    );

    assign more_words = (words_q != count_q) && !empty_s;
    assign capture    = (state_q == S_STRB_LO) && (elapsed == DV_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = (req_count == '0) ? S_FINISH : S_SETUP;
            S_SETUP:    if (elapsed == SETUP_LAST) state_d = S_OPEN;
            S_OPEN:     if (elapsed == LEAD_LAST)  state_d = S_CHECK;
            S_CHECK:    state_d = more_words ? S_STRB_LO : S_CLOSE_OE;
            S_STRB_LO:  if (elapsed == LOW_LAST)   state_d = S_STRB_HI;
            S_STRB_HI:  if (elapsed == HIGH_LAST)  state_d = S_CHECK;
            S_CLOSE_OE: if (elapsed == OFF_LAST)   state_d = S_RELEASE;
            S_RELEASE:  if (elapsed == HOLD_LAST)  state_d = S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Pin and status outputs from state
    always_comb begin
        fifo_cs_n = 1'b1;
        fifo_oe_n = 1'b1;
        fifo_rd_n = 1'b1;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:     busy = 1'b0;
            S_SETUP:    fifo_cs_n = 1'b0;
            S_OPEN, S_CHECK, S_STRB_HI: begin
                fifo_cs_n = 1'b0;
                fifo_oe_n = 1'b0;
            end
            S_STRB_LO: begin
                fifo_cs_n = 1'b0;
                fifo_oe_n = 1'b0;
                fifo_rd_n = 1'b0;
            end
            S_CLOSE_OE: fifo_cs_n = 1'b0;
            S_RELEASE:  ;
            S_FINISH:   done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    // Request capture and word return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            count_q   <= '0;
            words_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (state_q == S_IDLE && req_valid) begin
                addr_q  <= req_addr;
                count_q <= req_count;
                words_q <= '0;
            end
            if (capture) begin
                rsp_data  <= fifo_data;
                rsp_valid <= 1'b1;
                words_q   <= words_q + 1'b1;
            end
        end
    end

    assign fifo_addr  = addr_q;
    assign done_count = words_q;

    // Assertions
    p_oe_leads_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_rd_n) |-> $past(!fifo_oe_n) && !fifo_cs_n);

    p_no_stale_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!fifo_rd_n));

    p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STRB_LO && elapsed < LOW_LAST) |=> !fifo_rd_n);

    p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STRB_HI && elapsed < HIGH_LAST) |=> fifo_rd_n);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_cs_n && $past(!fifo_cs_n)) |-> $stable(fifo_addr));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_count <= count_q);

    p_close_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_oe_n) |-> fifo_rd_n && !fifo_cs_n);

    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && req_count == '0) |=> done && fifo_cs_n);

endmodule

// File: tb/fifo_rd_seq_tb_top.sv
module fifo_rd_seq_tb_top;

    localparam int AW = 3, DW = 16, CW = 6;
    localparam int T_SETUP = 2, T_OELEAD = 1, T_LOW = 3, T_HIGH = 2;
    localparam int T_DV = 3, T_HOLD = 2, T_OEOFF = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic busy, rsp_valid, done, fifo_cs_n, fifo_oe_n, fifo_rd_n, fifo_empty;
    logic [DW-1:0] rsp_data, fifo_data;
    logic [CW-1:0] done_count;
    logic [AW-1:0] fifo_addr;

    always #2 clk = ~clk;

    fifo_rd_seq #(.AW(AW), .DW(DW), .CW(CW), .T_SETUP(T_SETUP), .T_OELEAD(T_OELEAD),
        .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_DV(T_DV), .T_HOLD(T_HOLD),
        .T_OEOFF(T_OEOFF), .SYNC_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .done(done), .done_count(done_count), .fifo_cs_n(fifo_cs_n),
        .fifo_oe_n(fifo_oe_n), .fifo_rd_n(fifo_rd_n), .fifo_addr(fifo_addr),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty));

    // FIFO model
    logic [DW-1:0] mem [64];
    int rd_ptr = 0, avail = 0, lo_cnt = 0;
    assign fifo_empty = (rd_ptr >= avail);
    assign fifo_data  = (!fifo_oe_n && !fifo_rd_n && lo_cnt >= T_DV) ? mem[rd_ptr]
                                                                       : (16'hBAD0 ^ DW'(rd_ptr));

    // Monitor state
    logic prev_rd = 1'b1, prev_oe = 1'b1, prev_cs = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [AW-1:0] exp_addr = '0;
    int lo_run = 0, hi_run = 0, beats = 0, oe_falls = 0, oe_rises = 0, cs_falls = 0, cs_rises = 0;
    int v_low = 0, v_high = 0, v_order = 0, v_addr = 0, v_close = 0, v_lead = 0;
    int tail_hold = 0, v_hold = 0;
    logic [DW-1:0] got [64];
    int n_got = 0;
    int n_checks = 0, n_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fifo_rd_n) lo_cnt++; else lo_cnt = 0;
            if (prev_rd && !fifo_rd_n) begin
                if (beats > 0 && hi_run < T_HIGH) v_high++;
                if (prev_oe || fifo_oe_n || fifo_cs_n) v_order++;
                if (!prev_rd || prev_oe) v_lead++;
                beats++; hi_run = 0; lo_run = 1;
            end else if (!fifo_rd_n) lo_run++;
            if (!prev_rd && fifo_rd_n) begin
                if (lo_run < T_LOW) v_low++;
                rd_ptr++; tail_hold = 0;
            end
            if (fifo_rd_n && beats > 0 && !fifo_cs_n) hi_run++;
            if (beats > 0 && fifo_rd_n && fifo_addr == exp_addr) tail_hold++;
            if (beats > 0 && fifo_addr != exp_addr && tail_hold < T_OEOFF + T_HOLD) v_hold++;
            if (prev_oe && !fifo_oe_n) begin oe_falls++; if (fifo_cs_n || prev_cs) v_order++; end
            if (!prev_oe && fifo_oe_n) begin oe_rises++; if (!fifo_rd_n || fifo_cs_n) v_close++; end
            if (prev_cs && !fifo_cs_n) cs_falls++;
            if (!prev_cs && fifo_cs_n) begin cs_rises++; if (!fifo_oe_n) v_close++; end
            if (!fifo_cs_n && fifo_addr != exp_addr) v_addr++;
            if (!prev_cs && !fifo_cs_n && fifo_addr != prev_addr) v_addr++;
            if (done && (!fifo_cs_n || !fifo_oe_n)) v_close++;
            if (rsp_valid && n_got < 64) begin got[n_got] = rsp_data; n_got++; end
            prev_rd = fifo_rd_n; prev_oe = fifo_oe_n; prev_cs = fifo_cs_n; prev_addr = fifo_addr;
        end
    end

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_words(input int cnt, input int avl);
        return (cnt < avl) ? cnt : avl;
    endfunction

    task automatic run_txn(input int addr, input int cnt, input int avl, input bit bump);
        int ew, wait_n, dmis;
        for (int i = 0; i < 64; i++) mem[i] = DW'($urandom);
        avail = avl; rd_ptr = 0; n_got = 0; beats = 0;
        oe_falls = 0; oe_rises = 0; cs_falls = 0; cs_rises = 0;
        v_low = 0; v_high = 0; v_order = 0; v_addr = 0; v_close = 0; v_lead = 0;
        v_hold = 0; tail_hold = 0;
        exp_addr = AW'(addr);
        ew = exp_words(cnt, avl);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(addr); req_count = CW'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        if (cnt == 0) begin
            chk("R10 done one cycle after zero request", done === 1'b1, int'(done), 1);
            chk("R10 zero done_count", done_count == 0, int'(done_count), 0);
        end else begin
            chk("R9 busy after accept", busy === 1'b1 && done === 1'b0, int'(busy), 1);
            if (bump) begin
                req_valid = 1'b1; req_addr = AW'(addr + 1); req_count = CW'(cnt + 1);
                @(negedge clk);
                req_valid = 1'b0;
            end
            wait_n = 0;
            while (done !== 1'b1 && wait_n < 2000) begin @(negedge clk); wait_n++; end
            chk("R9 done reached", done === 1'b1, wait_n, -1);
            chk("R8 done_count", int'(done_count) == ew, int'(done_count), ew);
        end
        chk("R8 responses", n_got == ew, n_got, ew);
        chk("R8 strobe beats", beats == ew, beats, ew);
        dmis = 0;
        for (int i = 0; i < ew && i < n_got; i++) if (got[i] !== mem[i]) dmis++;
        chk("R5 R2 captured words", dmis == 0, dmis, 0);
        chk("R3 low width", v_low == 0, v_low, 0);
        chk("R4 high width", v_high == 0, v_high, 0);
        chk("R1 pin order", v_order == 0 && v_lead == 0, v_order + v_lead, 0);
        chk("R6 single oe window", oe_falls == (cnt ? 1 : 0) && oe_rises == oe_falls, oe_falls, cnt ? 1 : 0);
        chk("R6 single cs window", cs_falls == (cnt ? 1 : 0) && cs_rises == cs_falls, cs_falls, cnt ? 1 : 0);
        chk("R7 address stable", v_addr == 0 && v_hold == 0, v_addr + v_hold, 0);
        chk("R9 close order", v_close == 0, v_close, 0);
        @(negedge clk);
        chk("R9 idle after done", busy === 1'b0 && done === 1'b0, int'(busy), 0);
        if (bump) begin
            @(negedge clk);
            chk("R9 request while busy ignored", busy === 1'b0 && fifo_cs_n === 1'b1, int'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R11 reset pins", fifo_cs_n === 1'b1 && fifo_oe_n === 1'b1 && fifo_rd_n === 1'b1,
            int'({fifo_cs_n, fifo_oe_n, fifo_rd_n}), 7);
        chk("R11 reset status", busy === 1'b0 && done === 1'b0 && rsp_valid === 1'b0,
            int'({busy, done, rsp_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_txn(3, 0, 5, 1'b0);
        run_txn(1, 1, 5, 1'b0);
        run_txn(2, 5, 0, 1'b0);
        run_txn(4, 8, 3, 1'b0);
        run_txn(7, 63, 63, 1'b0);
        run_txn(5, 6, 10, 1'b1);
        run_txn(6, 4, 4, 1'b0);
        for (int k = 0; k < 16; k++)
            run_txn(int'($urandom % 8), int'($urandom % 20), int'($urandom % 24), k[0]);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule